// File: doc/BRIEF.md
# RAM-backed fixed delay line

This block delays a stream of W-bit samples by a fixed number of shifts, N. It acts like a chain of N registers, but the samples are not moved from stage to stage. Each sample is written once into a small RAM and read back N shifts later. Two address pointers walk around the RAM, and they are the only state that changes on every shift. The result is a long delay whose cost grows mainly with RAM words, not with flip-flops.

A shift happens on each rising clock edge where the enable is high and reset is low. At that edge the incoming sample is stored, and the oldest stored sample moves into the output register. When the enable is low, nothing moves and the output keeps its value. The RAM is not cleared by reset. The first N outputs after a reset are therefore don't-care and must be discarded by the user.

Top module: `dly_line`

## Requirements
- R1: For one cycle after a synchronous reset, `dataOut` is all zeros. In that cycle the read address is 0 and the write address is N-1.
- R2: Count the shifts since the last reset as c, and number the samples taken as s[0] (first) to s[c-1] (latest). When c is at least N, `dataOut` equals s[c-N] after the edge of shift c.
- R3: A clock edge with `shiftEn` low leaves `dataOut` unchanged.
- R4: Idle edges do not count toward the delay and do not lose samples. R2 holds in units of shifts for any pattern of enable gaps.
- R5: Both addresses step by one on every shift and wrap from N-1 to 0. The write address always equals (read address + N-1) mod N. The delay therefore stays correct over any number of wraps, including for an N that is not a power of two.
- R6: A reset applied in the middle of a stream restarts the block. R1 and R2 then hold again, with c counted from the new reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| shiftEn | input | 1 | Shift enable: store `dataIn` and advance the line |
| dataIn | input | W | Incoming sample |
| dataOut | output | W | Sample taken N shifts earlier (registered) |

## Verification
The hardest case to reach is an address wrap that falls inside an enable gap. A wrong pointer then shows up only as a delay that is off by one, many shifts later. To reach it, the stimulus runs long streams with random enable densities of about 30 %, 70 % and 100 %. These streams cross the wrap of a non-power-of-two depth many times. A reference queue, indexed by shift count, is compared after every edge. A reset in the middle of the stream checks that the restart rule applies again.

// File: rtl/dly_line_pkg.sv
package dly_line_pkg;
  typedef struct packed {
    logic clearOut;   // force output register to zero
    logic wrStrobe;   // store the incoming sample
    logic rdStrobe;   // load output register from RAM
  } dlyStrobeT;
endpackage

// File: rtl/dly_line_ctrl.sv
module dly_line_ctrl
  import dly_line_pkg::*;
#(
  parameter int N  = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shiftEn,
  output logic [AW-1:0] rdPtr,
  output logic [AW-1:0] wrPtr,
  output dlyStrobeT     strobes
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  function automatic logic [AW-1:0] stepPtr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= LAST;
    end else if (shiftEn) begin
      rdPtr <= stepPtr(rdPtr);
      wrPtr <= stepPtr(wrPtr);
    end
  end

  always_comb begin
    strobes.clearOut = rst;
    strobes.wrStrobe = shiftEn & ~rst;
    strobes.rdStrobe = shiftEn & ~rst;
  end
endmodule

// File: rtl/dly_line_dp.sv
module dly_line_dp
  import dly_line_pkg::*;
#(
  parameter int N  = 12,
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  dlyStrobeT     strobes,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  dataIn,
  output logic [W-1:0]  dataOut
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (strobes.wrStrobe) mem[wrAddr] <= dataIn;
  end

  // The read sees the old contents; the addresses never collide when N >= 2
  always_ff @(posedge clk) begin
    if (strobes.clearOut)      dataOut <= '0;
    else if (strobes.rdStrobe) dataOut <= mem[rdAddr];
  end
endmodule

// File: rtl/dly_line.sv
module dly_line
  import dly_line_pkg::*;
#(
  parameter int N = 12,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftEn,
  input  logic [W-1:0] dataIn,
  output logic [W-1:0] dataOut
);
  localparam int AW = (N > 2) ? $clog2(N) : 1;

  generate
    if (N < 2) begin : g_bad_depth
      $error("dly_line: depth N must be at least 2");
    end
  endgenerate

  logic [AW-1:0] rdPtr;
  logic [AW-1:0] wrPtr;
  dlyStrobeT     strobes;

  dly_line_ctrl #(.N(N), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .shiftEn(shiftEn),
    .rdPtr(rdPtr), .wrPtr(wrPtr), .strobes(strobes)
  );

  dly_line_dp #(.N(N), .W(W), .AW(AW)) u_dp (
    .clk(clk), .strobes(strobes), .rdAddr(rdPtr), .wrAddr(wrPtr),
    .dataIn(dataIn), .dataOut(dataOut)
  );
endmodule

// File: rtl/dly_line_chk.sv
module dly_line_chk #(
  parameter int N  = 12,
  parameter int W  = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          shiftEn,
  input logic [W-1:0]  dataOut,
  input logic [AW-1:0] rdPtr,
  input logic [AW-1:0] wrPtr
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);
  logic armed = 1'b0;

  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  // R1: reset leaves a zero output and the starting addresses
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    armed && $past(rst) |-> dataOut == '0 && rdPtr == '0 && wrPtr == LAST);

  // R3: an idle edge moves nothing
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && !$past(shiftEn) |->
      $stable(dataOut) && $stable(rdPtr) && $stable(wrPtr));

  // R5: read address steps by one with wrap on every shift
  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(shiftEn) |->
      rdPtr == (($past(rdPtr) == LAST) ? '0 : $past(rdPtr) + 1'b1));

  // R5: the two addresses keep a fixed distance of N-1
  p_gap_r5: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) |->
      32'(wrPtr) == (32'(rdPtr) + N - 1) % N);

  // R5: addresses never leave the RAM range
  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    armed |-> rdPtr <= LAST && wrPtr <= LAST);
endmodule

bind dly_line dly_line_chk #(.N(N), .W(W), .AW(AW)) u_chk (.*);

// File: tb/dly_line_tb.sv
module dly_line_tb;
  localparam int N = 12;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shiftEn = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  int hist[$];
  logic [W-1:0] prevOut;

  always #10 clk = ~clk;

  dly_line #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst(rst), .shiftEn(shiftEn), .dataIn(dataIn), .dataOut(dataOut)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dataOut=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive on the falling edge, check a quarter period after the rising edge
  task automatic step(input logic en, input logic [W-1:0] d, input string req);
    @(negedge clk);
    prevOut = dataOut;
    shiftEn = en;
    dataIn  = d;
    @(posedge clk);
    if (en) hist.push_back(int'(d));
    #5;
    if (!en) check({req, " hold (R3)"}, dataOut, prevOut);
    else if (hist.size() >= N) check(req, dataOut, W'(hist[hist.size() - N]));
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    rst = 1'b1;
    shiftEn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(req, dataOut, '0);
    hist.delete();
  endtask

  task automatic stream(input int cycles, input int pct, input string req);
    for (int i = 0; i < cycles; i++)
      step(($urandom % 100) < pct, W'($urandom), req);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset("R1 reset output zero");
    // R2: continuous shifting, sequential values
    for (int i = 0; i < 3 * N; i++) step(1'b1, W'(i + 1), "R2 continuous delay");
    // R3: long idle stretch
    for (int i = 0; i < 5; i++) step(1'b0, W'($urandom), "R3 idle");
    // R4 / R5: sparse, dense and full enable over many wraps
    stream(400, 30, "R4 sparse enable delay");
    stream(400, 70, "R4 dense enable delay");
    stream(300, 100, "R5 wrap delay");
    // R6: reset in the middle of a stream, then verify again
    stream(N / 2, 100, "R6 pre-reset");
    doReset("R6 mid-stream reset zero");
    stream(N - 1, 100, "R6 warmup");
    step(1'b1, 8'hA5, "R6 restart");
    stream(200, 50, "R6 restart delay");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule